// File: doc/BRIEF.md
# Loadable Range-Bounded Counter

This block is a small synchronous up-counter that steps around a closed window of values, from a lower bound `LO` up to an upper bound `HI`, both set by parameters with `0 <= LO <= HI <= 2**W-1`. When the counter is enabled and the present value equals `HI`, the next value is taken from the lower bound instead of the incremented count, so the sequence is `LO, LO+1, ..., HI, LO, ...`. With `LO = 0` it acts as a modulo-(`HI`+1) counter.

Three control inputs share a fixed priority: a synchronous clear beats a parallel load, and a parallel load beats counting. Both of them also beat the internal wrap. A value outside the window can only be reached through the parallel load. From such a value the counter steps upward in plain binary, rolling over from all ones to zero, until it lands on `HI`. At that point the wrap takes effect. A terminal flag is raised while the count sits at `HI` with counting enabled, so that a second stage can be chained to it.

Each cycle a small controller picks one of five named actions: CLEAR, LOAD, WRAP, STEP or HOLD. The datapath then computes the next value for that action.

Top module: `range_counter`

## Requirements
- R1: When `clr_i` is 1 at a rising clock edge, `q_o` becomes 0 whatever the other inputs are (action CLEAR).
- R2: When `clr_i` is 0 and `load_i` is 1, `q_o` becomes `d_i` after the edge (action LOAD).
- R3: When `clr_i` and `load_i` are 0, `en_i` is 1 and `q_o` is not `HI`, `q_o` becomes `q_o+1` modulo 2**W (action STEP).
- R4: When `clr_i` and `load_i` are 0, `en_i` is 1 and `q_o` equals `HI`, `q_o` becomes `LO` (action WRAP).
- R5: When `clr_i`, `load_i` and `en_i` are all 0, `q_o` keeps its value (action HOLD).
- R6: `tc_o` is 1 exactly when `q_o` equals `HI` and `en_i` is 1. It does not depend on `clr_i` or `load_i`.
- R7: A value above `HI` that was set by the load steps upward when enabled, and all ones steps to 0. A value below `LO` also steps upward until it reaches `HI`.
- R8: At `q_o == HI` with `en_i` 1, an asserted `clr_i` or `load_i` overrides the wrap to `LO`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| clr_i | input | 1 | Synchronous clear, highest priority |
| load_i | input | 1 | Parallel load request |
| en_i | input | 1 | Count enable |
| d_i | input | W | Parallel load value |
| q_o | output | W | Present count |
| tc_o | output | 1 | Terminal flag: count at `HI` while enabled |

## Verification
If the controller picks the wrong action, the error appears on `q_o` one edge later. A bad priority decode shows up as a load or clear being ignored, and a bad wrap decode shows up as `HI` stepping to `HI+1` instead of `LO`. A wrong terminal decode shows up on `tc_o` in the same cycle, before any edge. The sweep starts from every possible value with every control combination, so each error is exposed by a single transition.

// File: rtl/rc_pkg.sv
package rc_pkg;
    typedef enum logic [2:0] {
        ACT_HOLD  = 3'd0,
        ACT_STEP  = 3'd1,
        ACT_WRAP  = 3'd2,
        ACT_LOAD  = 3'd3,
        ACT_CLEAR = 3'd4
    } act_t;
endpackage

// File: rtl/rc_ctrl.sv
module rc_ctrl
    import rc_pkg::*;
#(
    parameter int W  = 4,
    parameter int HI = 11
) (
    input  logic         clr_i,
    input  logic         load_i,
    input  logic         en_i,
    input  logic [W-1:0] q_i,
    output act_t         act_o
);
    localparam logic [W-1:0] HI_V = W'(HI);

    logic at_top;
    assign at_top = (q_i == HI_V);

    // fixed priority: clear, load, wrap/step, hold
    always_comb begin
        if (clr_i)            act_o = ACT_CLEAR;
        else if (load_i)      act_o = ACT_LOAD;
        else if (en_i)        act_o = at_top ? ACT_WRAP : ACT_STEP;
        else                  act_o = ACT_HOLD;
    end
endmodule

// File: rtl/rc_next.sv
module rc_next
    import rc_pkg::*;
#(
    parameter int W  = 4,
    parameter int LO = 5
) (
    input  act_t         act_i,
    input  logic [W-1:0] q_i,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_nx_o
);
    localparam logic [W-1:0] LO_V = W'(LO);

    always_comb begin
        unique case (act_i)
            ACT_CLEAR: q_nx_o = '0;
            ACT_LOAD:  q_nx_o = d_i;
            ACT_WRAP:  q_nx_o = LO_V;
            ACT_STEP:  q_nx_o = q_i + W'(1);
            ACT_HOLD:  q_nx_o = q_i;
            default:   q_nx_o = q_i;
        endcase
    end
endmodule

// File: rtl/rc_term.sv
module rc_term #(
    parameter int W  = 4,
    parameter int HI = 11
) (
    input  logic         en_i,
    input  logic [W-1:0] q_i,
    output logic         tc_o
);
    localparam logic [W-1:0] HI_V = W'(HI);

    always_comb tc_o = en_i && (q_i == HI_V);
endmodule

// File: rtl/range_counter.sv
module range_counter
    import rc_pkg::*;
#(
    parameter int W  = 4,
    parameter int LO = 5,
    parameter int HI = 11
) (
    input  logic         clk,
    input  logic         clr_i,
    input  logic         load_i,
    input  logic         en_i,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o,
    output logic         tc_o
);
    act_t         act;
    logic [W-1:0] q_r;
    logic [W-1:0] q_nx;
    logic         tc_w;

    rc_ctrl #(.W(W), .HI(HI)) u_ctrl (
        .clr_i (clr_i),
        .load_i(load_i),
        .en_i  (en_i),
        .q_i   (q_r),
        .act_o (act)
    );

    rc_next #(.W(W), .LO(LO)) u_next (
        .act_i (act),
        .q_i   (q_r),
        .d_i   (d_i),
        .q_nx_o(q_nx)
    );

    rc_term #(.W(W), .HI(HI)) u_term (
        .en_i(en_i),
        .q_i (q_r),
        .tc_o(tc_w)
    );

    // state register
    always_ff @(posedge clk) begin
        q_r <= q_nx;
    end

    // outputs
    always_comb begin
        q_o  = q_r;
        tc_o = tc_w;
    end
endmodule

// File: rtl/rc_checker.sv
module rc_checker #(
    parameter int W  = 4,
    parameter int LO = 5,
    parameter int HI = 11
) (
    input logic         clk,
    input logic         clr_i,
    input logic         load_i,
    input logic         en_i,
    input logic [W-1:0] d_i,
    input logic [W-1:0] q_o,
    input logic         tc_o
);
    localparam logic [W-1:0] LO_V = W'(LO);
    localparam logic [W-1:0] HI_V = W'(HI);

    // counter value is unknown until the first clear has taken effect
    logic armed = 1'b0;
    always_ff @(posedge clk) if (clr_i) armed <= 1'b1;

    assert_clear_R1: assert property (@(posedge clk) disable iff (!armed)
        clr_i |=> (q_o == '0));

    assert_load_R2: assert property (@(posedge clk) disable iff (!armed)
        (!clr_i && load_i) |=> (q_o == $past(d_i)));

    assert_step_R3: assert property (@(posedge clk) disable iff (!armed)
        (!clr_i && !load_i && en_i && q_o != HI_V) |=> (q_o == W'($past(q_o) + W'(1))));

    assert_wrap_R4: assert property (@(posedge clk) disable iff (!armed)
        (!clr_i && !load_i && en_i && q_o == HI_V) |=> (q_o == LO_V));

    assert_hold_R5: assert property (@(posedge clk) disable iff (!armed)
        (!clr_i && !load_i && !en_i) |=> $stable(q_o));

    assert_term_R6: assert property (@(posedge clk) disable iff (!armed)
        tc_o |-> (en_i && q_o == HI_V));

    assert_term_seen_R6: assert property (@(posedge clk) disable iff (!armed)
        (en_i && q_o == HI_V) |-> tc_o);
endmodule

bind range_counter rc_checker #(.W(W), .LO(LO), .HI(HI)) u_chk (
    .clk   (clk),
    .clr_i (clr_i),
    .load_i(load_i),
    .en_i  (en_i),
    .d_i   (d_i),
    .q_o   (q_o),
    .tc_o  (tc_o)
);

// File: tb/tb_range_counter.sv
`timescale 1ns/1ps
module tb_range_counter;
    localparam int W  = 4;
    localparam int LO = 5;
    localparam int HI = 11;
    localparam int M  = 1 << W;

    logic         clk = 1'b0;
    logic         clr_i = 1'b0, load_i = 1'b0, en_i = 1'b0;
    logic [W-1:0] d_i = '0;
    logic [W-1:0] q_o;
    logic         tc_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    range_counter #(.W(W), .LO(LO), .HI(HI)) dut (
        .clk(clk), .clr_i(clr_i), .load_i(load_i), .en_i(en_i),
        .d_i(d_i), .q_o(q_o), .tc_o(tc_o)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: got %0d expected %0d", req, act, exp);
        end
    endtask

    // drive at the falling edge, let it settle, clock once, look after the next fall
    task automatic apply(input bit c, input bit l, input bit e, input int d);
        @(negedge clk);
        clr_i = c; load_i = l; en_i = e; d_i = W'(d);
    endtask

    task automatic set_state(input int s);
        apply(1'b0, 1'b1, 1'b0, s);
        @(negedge clk);
    endtask

    initial begin
        // reset state through clear (R1)
        apply(1'b1, 1'b1, 1'b1, 9);
        @(negedge clk);
        check("R1", int'(q_o), 0);

        // every start value with every control combination
        for (int s = 0; s < M; s++) begin
            for (int k = 0; k < 8; k++) begin
                bit c = k[2], l = k[1], e = k[0];
                int d = (s * 7 + 3 + k) % M;
                int exp_q;
                string tag;
                set_state(s);
                clr_i = c; load_i = l; en_i = e; d_i = W'(d);
                #1;
                check("R6", int'(tc_o), (e && s == HI) ? 1 : 0);
                if (c) begin
                    exp_q = 0;
                    tag = (e && s == HI) ? "R8" : "R1";
                end else if (l) begin
                    exp_q = d;
                    tag = (e && s == HI) ? "R8" : "R2";
                end else if (e) begin
                    if (s == HI) begin exp_q = LO; tag = "R4"; end
                    else begin
                        exp_q = (s + 1) % M;
                        tag = (s > HI || s < LO) ? "R7" : "R3";
                    end
                end else begin
                    exp_q = s; tag = "R5";
                end
                @(negedge clk);
                check(tag, int'(q_o), exp_q);
            end
        end

        // long run from above the window: 14,15,0,...,11,5,6,... (R7, R4)
        set_state(14);
        en_i = 1'b1; load_i = 1'b0;
        begin
            int m = 14;
            for (int i = 0; i < 40; i++) begin
                m = (m == HI) ? LO : (m + 1) % M;
                @(negedge clk);
                check("R7", int'(q_o), m);
            end
        end
        en_i = 1'b0;
        done = 1'b1;
    end

    initial begin
        fork
            begin wait (done); end
            begin
                repeat (200000) @(posedge clk);
                fails++;
                $display("FAIL watchdog: got timeout expected completion");
            end
        join_any
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule